// File: doc/BRIEF.md
# Logic Analyzer Host Command Sequencer

This block is the host-side controller of a single-channel logic analyzer. It sits between a byte stream from a serial receiver and a byte stream to a serial transmitter, both using valid/ready handshakes. On the other side it connects to a capture engine and to the read port of that engine's sample buffer. The controller sends its own status bytes. It tells the host when it is ready, arms the engine, and reports when capture is complete. After that it waits for one-letter ASCII commands from the host.

Three commands exist. The first restarts capture from a cleared buffer. The second dumps the buffer: one byte with the number of captured entries, then every slot of the buffer as a 16-bit word, sent upper byte first. Slots that hold no capture still go out with whatever filler they contain. The third command reports the current level of the probe input as an ASCII digit.

Every outgoing byte waits on transmitter back-pressure. The buffer read port has one cycle of latency.

Top module: `lacq_host_seq`

## Requirements
- R1: After reset is released, `cap_clear` is high for exactly one cycle. Then 0x72 is offered on the transmit stream. `cap_arm` pulses for one cycle, in the cycle after that byte is accepted.
- R2: While capture runs (after arming and before `cap_done`), received bytes are consumed and discarded: nothing is transmitted and `cap_clear`/`cap_arm` stay low. Once `cap_done` is sampled high, 0x66 is offered in the next cycle, and the controller then waits for commands.
- R3: In the command-wait state, the received byte 0x72 restarts the controller. It repeats the R1 sequence: a one-cycle `cap_clear`, then 0x72, then a one-cycle `cap_arm`.
- R4: In the command-wait state, the received byte 0x74 starts a dump. The first byte sent is `cap_count`, captured in the cycle the command is accepted. Then slots 0 to SLOTS-1 follow in ascending address order. Each slot sends `buf_data[15:8]` and then `buf_data[7:0]`, read one cycle after `buf_addr` is driven. `buf_addr` stays stable while a slot is being sent.
- R5: In the command-wait state, the received byte 0x73 returns 0x31 if `probe_in` was high when the command was accepted, and 0x30 if it was low.
- R6: In the command-wait state, any other received byte transmits nothing, leaves `cap_clear`/`cap_arm` low, and keeps the controller waiting for commands.
- R7: A byte offered with `tx_valid` high keeps `tx_valid` high and `tx_data` unchanged until `tx_ready` is seen high at a clock edge. No further byte is offered before that.
- R8: After the last byte of a dump or of a level reply is accepted, the controller is back in the command-wait state. It acts on a command presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Always high; bytes are consumed every cycle |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| cap_clear | output | 1 | One-cycle pulse: clear buffer and entry count |
| cap_arm | output | 1 | One-cycle pulse: start capturing |
| cap_done | input | 1 | Capture engine has finished |
| cap_count | input | CNT_W | Number of captured entries |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_data | input | 16 | Buffer read data, one cycle after the address |
| probe_in | input | 1 | Synchronised probe level |

## Verification
Each result arrives at a fixed cycle after its trigger:
- A command accepted at an edge puts its first reply byte on `tx_data` in the next cycle.
- `cap_done` sampled at an edge puts 0x66 on `tx_data` in the next cycle.
- `cap_arm` follows the accepted 0x72 by one cycle.
- Each dump slot spends one address cycle before its upper byte is offered.

The bench builds the expected byte stream from the requirements and samples on the falling edge. It records the handshake values seen there, because those are the values the rising edge consumes. Each accepted byte is compared one half-cycle after its handshake. Stalls driven by a pseudo-random `tx_ready` are checked for a held byte on every clock.

// File: rtl/lacq_host_pkg.sv
package lacq_host_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_CLEAR, ST_HELLO, ST_ARM, ST_RUN, ST_FIN, ST_IDLE,
    ST_COUNT, ST_FETCH, ST_HIGH, ST_LOW, ST_LEVEL
  } seq_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_RESTART, OP_DUMP, OP_LEVEL} host_op_e;

  localparam logic [BYTE_W-1:0] CH_READY = 8'h72;
  localparam logic [BYTE_W-1:0] CH_DONE  = 8'h66;
  localparam logic [BYTE_W-1:0] CH_DUMP  = 8'h74;
  localparam logic [BYTE_W-1:0] CH_LEVEL = 8'h73;
  localparam logic [BYTE_W-1:0] CH_ZERO  = 8'h30;

  function automatic host_op_e decode_op(input logic [BYTE_W-1:0] b);
    case (b)
      CH_READY: return OP_RESTART;
      CH_DUMP:  return OP_DUMP;
      CH_LEVEL: return OP_LEVEL;
      default:  return OP_NONE;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] level_char(input logic lvl);
    return CH_ZERO + {{(BYTE_W-1){1'b0}}, lvl};
  endfunction

  function automatic logic [BYTE_W-1:0] word_half(input logic [2*BYTE_W-1:0] w,
                                                  input logic upper);
    return upper ? w[2*BYTE_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/lacq_cmd_decode.sv
module lacq_cmd_decode
  import lacq_host_pkg::*;
(
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              listening,
  output host_op_e          op
);
  always_comb begin
    op = OP_NONE;
    if (in_valid && listening) op = decode_op(in_byte);
  end
endmodule

// File: rtl/lacq_slot_walker.sv
module lacq_slot_walker #(
  parameter  int SLOTS = 55,
  localparam int IW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  output logic [IW-1:0] idx,
  output logic          at_end
);
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (restart) idx <= '0;
    else if (advance) idx <= idx + 1'b1;
  end

  assign at_end = (idx == LAST);

  AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !at_end); // R4
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST); // R4
endmodule

// File: rtl/lacq_tx_select.sv
module lacq_tx_select
  import lacq_host_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  seq_state_e          st,
  input  logic [CNT_W-1:0]    count_q,
  input  logic                level_q,
  input  logic [2*BYTE_W-1:0] word,
  output logic                valid,
  output logic [BYTE_W-1:0]   data
);
  always_comb begin
    valid = 1'b1;
    data  = '0;
    case (st)
      ST_HELLO: data = CH_READY;
      ST_FIN:   data = CH_DONE;
      ST_COUNT: data = BYTE_W'(count_q);
      ST_HIGH:  data = word_half(word, 1'b1);
      ST_LOW:   data = word_half(word, 1'b0);
      ST_LEVEL: data = level_char(level_q);
      default:  valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/lacq_host_seq.sv
module lacq_host_seq
  import lacq_host_pkg::*;
#(
  parameter  int SLOTS  = 55,
  localparam int ADDR_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              cap_clear,
  output logic              cap_arm,
  input  logic              cap_done,
  input  logic [CNT_W-1:0]  cap_count,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [15:0]       buf_data,
  input  logic              probe_in
);
  seq_state_e       st, st_nxt;
  host_op_e         op;
  logic [CNT_W-1:0] count_q;
  logic             level_q;
  logic             tx_fire;
  logic             slot_last;
  logic             slot_step;
  logic             dump_start;
  logic             listening;

  assign rx_ready   = 1'b1;
  assign listening  = (st == ST_IDLE);
  assign tx_fire    = tx_valid && tx_ready;
  assign dump_start = (op == OP_DUMP);
  assign slot_step  = (st == ST_LOW) && tx_ready && !slot_last;
  assign cap_clear  = (st == ST_CLEAR);
  assign cap_arm    = (st == ST_ARM);

  lacq_cmd_decode u_decode (
    .in_valid (rx_valid),
    .in_byte  (rx_data),
    .listening(listening),
    .op       (op)
  );

  lacq_slot_walker #(.SLOTS(SLOTS)) u_walker (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(dump_start),
    .advance(slot_step),
    .idx    (buf_addr),
    .at_end (slot_last)
  );

  lacq_tx_select #(.CNT_W(CNT_W)) u_txsel (
    .st     (st),
    .count_q(count_q),
    .level_q(level_q),
    .word   (buf_data),
    .valid  (tx_valid),
    .data   (tx_data)
  );

  always_comb begin
    st_nxt = st;
    case (st)
      ST_CLEAR: st_nxt = ST_HELLO;
      ST_HELLO: if (tx_ready) st_nxt = ST_ARM;
      ST_ARM:   st_nxt = ST_RUN;
      ST_RUN:   if (cap_done) st_nxt = ST_FIN;
      ST_FIN:   if (tx_ready) st_nxt = ST_IDLE;
      ST_IDLE: begin
        case (op)
          OP_RESTART: st_nxt = ST_CLEAR;
          OP_DUMP:    st_nxt = ST_COUNT;
          OP_LEVEL:   st_nxt = ST_LEVEL;
          default:    st_nxt = ST_IDLE;
        endcase
      end
      ST_COUNT: if (tx_ready) st_nxt = ST_FETCH;
      ST_FETCH: st_nxt = ST_HIGH;
      ST_HIGH:  if (tx_ready) st_nxt = ST_LOW;
      ST_LOW:   if (tx_ready) st_nxt = slot_last ? ST_IDLE : ST_FETCH;
      ST_LEVEL: if (tx_ready) st_nxt = ST_IDLE;
      default:  st_nxt = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_CLEAR;
      count_q <= '0;
      level_q <= 1'b0;
    end else begin
      st <= st_nxt;
      if (op == OP_DUMP)  count_q <= cap_count;
      if (op == OP_LEVEL) level_q <= probe_in;
    end
  end

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R7
  AST_ARM_AFTER_HELLO: assert property (@(posedge clk) disable iff (!rst_n)
    cap_arm |-> $past(tx_fire && tx_data == CH_READY)); // R1
  AST_CLEAR_THEN_HELLO: assert property (@(posedge clk) disable iff (!rst_n)
    cap_clear |=> tx_valid && tx_data == CH_READY && !cap_clear); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && st == ST_HIGH |=> $stable(buf_addr)); // R4
  AST_LEVEL_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && st == ST_LEVEL |-> tx_data == CH_ZERO || tx_data == CH_ZERO + 8'd1); // R5
  AST_IGNORE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    listening && rx_valid && op == OP_NONE |=> listening && !tx_valid); // R6
  AST_DONE_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RUN && cap_done |=> tx_valid && tx_data == CH_DONE); // R2
endmodule

// File: tb/lacq_host_seq_tb_top.sv
module lacq_host_seq_tb_top;
  localparam int SLOTS  = 55;
  localparam int ADDR_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic cap_clear, cap_arm, cap_done = 1'b0;
  logic [CNT_W-1:0] cap_count = '0;
  logic [ADDR_W-1:0] buf_addr;
  logic [15:0] buf_data;
  logic probe_in = 1'b0;

  lacq_host_seq #(.SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .cap_clear(cap_clear), .cap_arm(cap_arm),
    .cap_done(cap_done), .cap_count(cap_count), .buf_addr(buf_addr),
    .buf_data(buf_data), .probe_in(probe_in)
  );

  logic [15:0] mem [SLOTS];
  always_ff @(posedge clk) buf_data <= mem[buf_addr];

  int nvec = 0, nbad = 0, cyc = 0, clear_cnt = 0, arm_cnt = 0;
  logic [7:0] expq[$];
  string tagq[$];
  logic hs_pend = 1'b0, stall_pend = 1'b0;
  logic [7:0] hs_data = '0, stall_data = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] b, input string req);
    expq.push_back(b);
    tagq.push_back(req);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nbad++;
      $display("FAIL watchdog: actual %0d expected 0 pending", expq.size());
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
    if (rst_n) begin
      if (cap_clear) clear_cnt++;
      if (cap_arm) arm_cnt++;
      if (hs_pend) begin
        if (expq.size() == 0) chk(1'b0, "R6 unexpected tx", hs_data, 0);
        else begin
          logic [7:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(hs_data == e, t, hs_data, e);
        end
      end
      if (stall_pend) chk(tx_valid && tx_data == stall_data, "R7 hold", tx_data, stall_data);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = lfsr[0] | lfsr[3];
      hs_pend = tx_valid && tx_ready;
      hs_data = tx_data;
      stall_pend = tx_valid && !tx_ready;
      stall_data = tx_data;
    end
  end

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic fill_mem(input int n);
    for (int i = 0; i < SLOTS; i++)
      mem[i] = (i < n) ? {8'(i * 7 + 3), 8'(8'hA0 ^ i)} : 16'h2323;
  endtask

  task automatic expect_dump(input int n);
    expect_byte(8'(n), "R4 count");
    for (int i = 0; i < SLOTS; i++) begin
      expect_byte(mem[i][15:8], "R4 high");
      expect_byte(mem[i][7:0], "R4 low");
    end
  endtask

  initial begin
    fill_mem(0);
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R1 reset tx_valid", tx_valid, 0);
    chk(!cap_arm, "R1 reset arm", cap_arm, 0);
    chk(rx_ready, "R2 rx_ready", rx_ready, 1);
    expect_byte(8'h72, "R1 hello");
    @(posedge clk);
    #1 rst_n = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    chk(clear_cnt == 1, "R1 clear pulses", clear_cnt, 1);
    chk(arm_cnt == 1, "R1 arm pulses", arm_cnt, 1);

    send_cmd(8'h74);
    send_cmd(8'h73);
    send_cmd(8'h72);
    repeat (20) @(negedge clk);
    chk(clear_cnt == 1 && arm_cnt == 1, "R2 discard during run", clear_cnt + arm_cnt, 2);

    expect_byte(8'h66, "R2 done");
    @(negedge clk) cap_done = 1'b1;
    @(negedge clk) cap_done = 1'b0;
    drain();

    probe_in = 1'b1;
    expect_byte(8'h31, "R5 high");
    send_cmd(8'h73);
    drain();
    probe_in = 1'b0;
    expect_byte(8'h30, "R5 low");
    send_cmd(8'h73);
    probe_in = 1'b1;
    drain();

    send_cmd(8'h41);
    send_cmd(8'h52);
    send_cmd(8'h00);
    repeat (20) @(negedge clk);
    chk(clear_cnt == 1 && arm_cnt == 1, "R6 ignored bytes", clear_cnt + arm_cnt, 2);
    chk(expq.size() == 0, "R6 no reply", expq.size(), 0);
    expect_byte(8'h31, "R8 still idle");
    send_cmd(8'h73);
    drain();

    fill_mem(5);
    cap_count = 6'd5;
    expect_dump(5);
    send_cmd(8'h74);
    cap_count = 6'd9;
    drain();
    probe_in = 1'b0;
    expect_byte(8'h30, "R8 after dump");
    send_cmd(8'h73);
    drain();

    fill_mem(0);
    cap_count = 6'd0;
    expect_dump(0);
    send_cmd(8'h74);
    drain();

    fill_mem(SLOTS);
    cap_count = 6'(SLOTS);
    expect_dump(SLOTS);
    send_cmd(8'h74);
    drain();

    expect_byte(8'h72, "R3 restart hello");
    send_cmd(8'h72);
    drain();
    repeat (3) @(negedge clk);
    chk(clear_cnt == 2, "R3 clear pulses", clear_cnt, 2);
    chk(arm_cnt == 2, "R3 arm pulses", arm_cnt, 2);
    expect_byte(8'h66, "R2 done again");
    @(negedge clk) cap_done = 1'b1;
    @(negedge clk) cap_done = 1'b0;
    drain();
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R7 queue empty", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule